// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block stands in for the sideband channel of a display link and answers EDID queries locally, with no traffic on a real wire. Software sees a small register window with one control word and five data words. To issue a request, software first loads the request header into the first data word. It then writes the control word with the send-busy bit set. In that same clock edge the block decodes the request, updates its EDID read session, rewrites the control word as a completed reply and puts an acknowledge (plus any returned byte) into the first data word.

Only the subset needed to fetch EDID is served. Address-only transactions start, restart or stop a session. Read requests return one byte each from a built-in 128-byte table and move a read pointer forward. Write requests get an acknowledge and change nothing. The session records which display port selected the EDID slave, and whether a sink is present there. Both are shown on status outputs.

Top module: `aux_edid_responder`

## Requirements
- R1: The window decodes offset 0x10 as the control word and 0x14, 0x18, 0x1C, 0x20, 0x24 as data words 1 to 5. A write to a data word is stored and reads back unchanged. Any other offset reads 0 and ignores writes. After reset every word reads 0.
- R2: A control write with bit 31 (send-busy) clear changes nothing: neither the control word nor any data word.
- R3: A control write with bit 31 set is a send. The control word becomes 0x4000_0000 (done, bit 30) plus a reply size in bits 24:20. The size is 2 when request opcode bit 0 is 1 (read) and 1 when it is 0 (write). The message length of the send is taken from bits 24:20 of the written value.
- R4: The request is read from data word 1: I2C address in bits 23:8, opcode in bits 31:28. Every send except the case in R9 overwrites data word 1 with the reply: acknowledge code 0x00 in bits 31:24, the returned byte in bits 23:16 (zero if there is none), and zero elsewhere.
- R5: A send with length 3, opcode bit 2 (continue) set and address 0x50 selects the EDID slave. It records the `port_idx` input and marks the table available exactly when `sink_present` is 1. The read pointer is not changed.
- R6: A send with length 3 and opcode bit 2 clear is a stop. It deselects, clears availability and the port, and zeroes the read pointer.
- R7: A send with length 3, opcode bit 2 set and address 0 resets the session as in R6.
- R8: A read send (opcode bit 0 = 1, length 4) while selected and available returns table byte p in bits 23:16 and advances p by one. Byte i of the table is (37*i + 0x5B) mod 256.
- R9: A read send whose length is neither 3 nor 4 still updates the control word per R3. It leaves data word 1 and the read pointer unchanged.
- R10: A read send while not selected or not available returns byte 0 with acknowledge, and the pointer does not move.
- R11: Once all 128 bytes have been read, further reads return 0 and the pointer stays at 128.
- R12: A write send (opcode bit 0 = 0, length not 3) is acknowledged and leaves the session unchanged.
- R13: A send with length 3, opcode bit 2 set and any address other than 0 or 0x50 leaves the session unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 8 | Low byte of the write offset |
| wr_data | input | 32 | Write data |
| rd_off | input | 8 | Low byte of the read offset |
| rd_data | output | 32 | Combinational read data |
| port_idx | input | 3 | Display port issuing the requests |
| sink_present | input | 1 | A sink is attached on that port |
| edid_sel | output | 1 | EDID slave currently selected |
| edid_port | output | 3 | Port recorded at selection |

## Verification
Most session faults show up in the very next reply word. A pointer that skips or stalls returns the wrong table byte on the following read. A stuck or missing selection gives zeros where data was expected, or data where zeros were expected. A decode fault in the control path is visible one cycle after the send, either in the control word's reply size or in data word 1 being written when it should have been kept. Faults at the 128-byte limit only appear after a full sweep of the table, so that sweep is checked byte by byte.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

    localparam int WORD_W      = 32;
    localparam int OFF_W       = 8;
    localparam int SLOT_W      = 3;
    localparam int LEN_W       = 5;
    localparam int LEN_LSB     = 20;
    localparam int BUSY_BIT    = 31;
    localparam int DONE_BIT    = 30;
    localparam logic [7:0] ACK_CODE    = 8'h00;
    localparam logic [7:0] OFF_CTL     = 8'h10;
    localparam logic [7:0] OFF_DATA0   = 8'h14;
    localparam logic [SLOT_W-1:0] SLOT_CTL  = '0;
    localparam logic [SLOT_W-1:0] SLOT_NONE = '1;

    typedef struct packed {
        logic [3:0]       opcode;
        logic [15:0]      i2c_addr;
        logic [LEN_W-1:0] msg_len;
    } aux_req_t;

    typedef enum logic [2:0] {
        ACT_IGNORE = 3'd0,
        ACT_STOP   = 3'd1,
        ACT_RESET  = 3'd2,
        ACT_SELECT = 3'd3,
        ACT_READ   = 3'd4,
        ACT_BADLEN = 3'd5
    } aux_act_t;

    function automatic logic [7:0] edid_byte(input int idx);
        int v;
        v = 37 * idx + 91;
        return v[7:0];
    endfunction

    function automatic logic [WORD_W-1:0] reply_ctl(input logic is_read);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DONE_BIT] = 1'b1;
        w[LEN_LSB +: LEN_W] = is_read ? LEN_W'(2) : LEN_W'(1);
        return w;
    endfunction

endpackage

// File: rtl/aux_req_decode.sv
module aux_req_decode
    import aux_edid_pkg::*;
#(
    parameter logic [15:0] EDID_ADDR = 16'h0050
) (
    input  logic [WORD_W-1:0] req_word,
    input  logic [LEN_W-1:0]  msg_len,
    output aux_req_t          req,
    output aux_act_t          act,
    output logic              is_read
);
    logic mot;
    logic unused_low;

    always_comb begin
        req.opcode   = req_word[31:28];
        req.i2c_addr = req_word[23:8];
        req.msg_len  = msg_len;
        unused_low   = ^{req_word[27:24], req_word[7:0]};
    end

    assign is_read = req.opcode[0];
    assign mot     = req.opcode[2];

    always_comb begin
        act = ACT_IGNORE;
        if (req.msg_len == LEN_W'(3)) begin
            if (!mot)
                act = ACT_STOP;
            else if (req.i2c_addr == 16'h0000)
                act = ACT_RESET;
            else if (req.i2c_addr == EDID_ADDR)
                act = ACT_SELECT;
            else
                act = ACT_IGNORE;
        end else if (is_read) begin
            act = (req.msg_len == LEN_W'(4)) ? ACT_READ : ACT_BADLEN;
        end
    end

endmodule

// File: rtl/aux_edid_session.sv
module aux_edid_session
    import aux_edid_pkg::*;
#(
    parameter int EDID_BYTES = 128,
    parameter int PORT_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  aux_act_t          act,
    input  logic [PORT_W-1:0] port_idx,
    input  logic              sink_present,
    output logic              sel,
    output logic [PORT_W-1:0] port,
    output logic [7:0]        byte_out
);
    localparam int PTR_W = $clog2(EDID_BYTES + 1);

    logic [PTR_W-1:0] ptr;
    logic             avail;
    logic             can_read;
    logic [7:0]       table_q [EDID_BYTES];

    for (genvar i = 0; i < EDID_BYTES; i++) begin : g_table
        assign table_q[i] = edid_byte(i);
    end

    assign can_read = sel && avail && (ptr < PTR_W'(EDID_BYTES));
    assign byte_out = can_read ? table_q[ptr[PTR_W-2:0]] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel   <= 1'b0;
            avail <= 1'b0;
            port  <= '0;
            ptr   <= '0;
        end else if (fire) begin
            case (act)
                ACT_STOP, ACT_RESET: begin
                    sel   <= 1'b0;
                    avail <= 1'b0;
                    port  <= '0;
                    ptr   <= '0;
                end
                ACT_SELECT: begin
                    sel   <= 1'b1;
                    avail <= sink_present;
                    port  <= port_idx;
                end
                ACT_READ: begin
                    if (can_read)
                        ptr <= ptr + PTR_W'(1);
                end
                default: ;
            endcase
        end
    end

    a_r11_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(EDID_BYTES));

    a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_STOP) |=> (!sel && ptr == '0));

    a_r8_ptr_only_on_fire: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(ptr));

    a_r10_no_advance: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_READ && !(sel && avail)) |=> $stable(ptr));

endmodule

// File: rtl/aux_reg_file.sv
module aux_reg_file
    import aux_edid_pkg::*;
#(
    parameter int NUM_DATA = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              send_fire,
    input  logic [WORD_W-1:0] ctl_reply,
    input  logic              reply_we,
    input  logic [WORD_W-1:0] reply_word,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] req_word
);
    logic [WORD_W-1:0] ctl_q;
    logic [WORD_W-1:0] data_q [NUM_DATA];

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (send_fire)
            ctl_q <= ctl_reply;
    end

    for (genvar k = 0; k < NUM_DATA; k++) begin : g_data
        always_ff @(posedge clk) begin
            if (rst)
                data_q[k] <= '0;
            else if (k == 0 && reply_we)
                data_q[k] <= reply_word;
            else if (wr_en && wr_slot == SLOT_W'(k + 1))
                data_q[k] <= wr_data;
        end
    end

    assign req_word = data_q[0];

    always_comb begin
        rd_data = '0;
        if (rd_slot == SLOT_CTL)
            rd_data = ctl_q;
        for (int k = 0; k < NUM_DATA; k++)
            if (rd_slot == SLOT_W'(k + 1))
                rd_data = data_q[k];
    end

    a_r2_ctl_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_slot == SLOT_CTL && !wr_data[BUSY_BIT]) |=> $stable(ctl_q));

    a_r3_done_posted: assert property (@(posedge clk) disable iff (rst)
        send_fire |=> (ctl_q[DONE_BIT] && !ctl_q[BUSY_BIT]));

    a_r9_req_kept: assert property (@(posedge clk) disable iff (rst)
        (send_fire && !reply_we) |=> $stable(data_q[0]));

endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
    import aux_edid_pkg::*;
#(
    parameter int          NUM_DATA   = 5,
    parameter int          EDID_BYTES = 128,
    parameter int          PORT_W     = 3,
    parameter logic [15:0] EDID_ADDR  = 16'h0050
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [WORD_W-1:0] rd_data,
    input  logic [PORT_W-1:0] port_idx,
    input  logic              sink_present,
    output logic              edid_sel,
    output logic [PORT_W-1:0] edid_port
);
    function automatic logic [SLOT_W-1:0] slot_of(input logic [OFF_W-1:0] off);
        logic [SLOT_W-1:0] s;
        s = SLOT_NONE;
        if (off == OFF_CTL)
            s = SLOT_CTL;
        for (int k = 0; k < NUM_DATA; k++)
            if (off == OFF_W'(OFF_DATA0 + 4 * k))
                s = SLOT_W'(k + 1);
        return s;
    endfunction

    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic              fire;
    logic [WORD_W-1:0] req_word;
    aux_req_t          req;
    aux_act_t          act;
    logic              is_read;
    logic [7:0]        byte_out;
    logic              reply_we;
    logic [WORD_W-1:0] reply_word;
    logic [WORD_W-1:0] ctl_reply;
    logic              unused_req;

    assign wr_slot = slot_of(wr_off);
    assign rd_slot = slot_of(rd_off);
    assign fire    = wr_en && (wr_slot == SLOT_CTL) && wr_data[BUSY_BIT];

    aux_req_decode #(.EDID_ADDR(EDID_ADDR)) u_dec (
        .req_word (req_word),
        .msg_len  (wr_data[LEN_LSB +: LEN_W]),
        .req      (req),
        .act      (act),
        .is_read  (is_read)
    );

    assign unused_req = ^req;

    aux_edid_session #(.EDID_BYTES(EDID_BYTES), .PORT_W(PORT_W)) u_sess (
        .clk          (clk),
        .rst          (rst),
        .fire         (fire),
        .act          (act),
        .port_idx     (port_idx),
        .sink_present (sink_present),
        .sel          (edid_sel),
        .port         (edid_port),
        .byte_out     (byte_out)
    );

    assign ctl_reply  = reply_ctl(is_read);
    assign reply_we   = fire && (act != ACT_BADLEN);
    assign reply_word = {ACK_CODE, (act == ACT_READ) ? byte_out : 8'h00, 16'h0000};

    aux_reg_file #(.NUM_DATA(NUM_DATA)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_data    (wr_data),
        .send_fire  (fire),
        .ctl_reply  (ctl_reply),
        .reply_we   (reply_we),
        .reply_word (reply_word),
        .rd_slot    (rd_slot),
        .rd_data    (rd_data),
        .req_word   (req_word)
    );

    a_r5_select_port: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_SELECT) |=> (edid_sel && edid_port == $past(port_idx)));

    a_r13_other_addr: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_IGNORE) |=> ($stable(edid_sel) && $stable(edid_port)));

endmodule

// File: tb/aux_edid_responder_bench.sv
module aux_edid_responder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_off = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_off = '0;
    logic [31:0] rd_data;
    logic [2:0]  port_idx = '0;
    logic        sink_present = 1'b0;
    logic        edid_sel;
    logic [2:0]  edid_port;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_edid_responder u_aux_edid_responder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .rd_off(rd_off), .rd_data(rd_data), .port_idx(port_idx),
        .sink_present(sink_present), .edid_sel(edid_sel), .edid_port(edid_port)
    );

    function automatic logic [7:0] tbl(input int i);
        return 8'((37 * i + 91) % 256);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, output logic [31:0] d);
        rd_off = off;
        #1;
        d = rd_data;
    endtask

    task automatic send(input logic [3:0] op, input logic [15:0] addr, input int len);
        wr(8'h14, {op, 4'h0, addr, 8'h00});
        wr(8'h10, 32'h8000_0000 | (32'(len) << 20));
    endtask

    task automatic read_byte(input string req, input logic [7:0] exp);
        logic [31:0] d;
        send(4'b0101, 16'h0, 4);
        rd(8'h10, d); check({req, " ctl"}, d, 32'h4020_0000);
        rd(8'h14, d); check(req, d, {8'h00, exp, 16'h0});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h10, d); check("R1 reset ctl", d, 0);
        for (int k = 0; k < 5; k++) begin
            rd(8'(8'h14 + 4 * k), d); check("R1 reset data", d, 0);
        end
        check("R1 reset sel", 32'(edid_sel), 0);
    endtask

    task automatic t_data_regs;
        logic [31:0] d;
        for (int k = 0; k < 5; k++) wr(8'(8'h14 + 4 * k), 32'hA000_0000 + 32'(k * 17));
        for (int k = 0; k < 5; k++) begin
            rd(8'(8'h14 + 4 * k), d); check("R1 data store", d, 32'hA000_0000 + 32'(k * 17));
        end
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, d); check("R1 unmapped", d, 0);
        rd(8'h10, d); check("R1 ctl untouched", d, 0);
    endtask

    task automatic t_ctl_idle;
        logic [31:0] d;
        wr(8'h14, 32'h5000_5000);
        wr(8'h10, 32'h0040_0000);
        rd(8'h10, d); check("R2 ctl idle", d, 0);
        rd(8'h14, d); check("R2 data1 idle", d, 32'h5000_5000);
    endtask

    task automatic t_write_req;
        logic [31:0] d;
        send(4'b0000, 16'h0050, 5);
        rd(8'h10, d); check("R3 write size", d, 32'h4010_0000);
        rd(8'h14, d); check("R12 write ack", d, 0);
    endtask

    task automatic t_select_read;
        logic [31:0] d;
        port_idx = 3'd3; sink_present = 1'b1;
        send(4'b0100, 16'h0050, 3);
        rd(8'h10, d); check("R3 select ctl", d, 32'h4010_0000);
        rd(8'h14, d); check("R4 select ack", d, 0);
        check("R5 sel", 32'(edid_sel), 1);
        check("R5 port", 32'(edid_port), 3);
        for (int i = 0; i < 3; i++) read_byte("R8 read", tbl(i));
    endtask

    task automatic t_mid_session;
        logic [31:0] d;
        send(4'b0100, 16'h1234, 6);
        rd(8'h14, d); check("R12 mid write ack", d, 0);
        read_byte("R12 continue", tbl(3));
        send(4'b0100, 16'h0037, 3);
        check("R13 sel kept", 32'(edid_sel), 1);
        read_byte("R13 continue", tbl(4));
    endtask

    task automatic t_badlen;
        logic [31:0] d;
        send(4'b0101, 16'h0000, 2);
        rd(8'h10, d); check("R9 ctl", d, 32'h4020_0000);
        rd(8'h14, d); check("R9 data1 kept", d, 32'h5000_0000);
        read_byte("R9 ptr kept", tbl(5));
    endtask

    task automatic t_stop;
        send(4'b0000, 16'h0050, 3);
        check("R6 stop sel", 32'(edid_sel), 0);
        check("R6 stop port", 32'(edid_port), 0);
        read_byte("R10 after stop", 8'h00);
    endtask

    task automatic t_addr0;
        port_idx = 3'd5;
        send(4'b0100, 16'h0050, 3);
        check("R5 port 5", 32'(edid_port), 5);
        read_byte("R6 ptr zeroed", tbl(0));
        send(4'b0100, 16'h0000, 3);
        check("R7 reset sel", 32'(edid_sel), 0);
        read_byte("R7 after reset", 8'h00);
    endtask

    task automatic t_no_sink;
        sink_present = 1'b0;
        send(4'b0100, 16'h0050, 3);
        check("R5 sel no sink", 32'(edid_sel), 1);
        read_byte("R10 no sink", 8'h00);
        sink_present = 1'b1;
        read_byte("R10 stale avail", 8'h00);
        send(4'b0000, 16'h0, 3);
    endtask

    task automatic t_overrun;
        send(4'b0100, 16'h0050, 3);
        for (int i = 0; i < 128; i++) read_byte("R8 sweep", tbl(i));
        read_byte("R11 past end", 8'h00);
        read_byte("R11 still end", 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_data_regs();
        t_ctl_idle();
        t_write_req();
        t_select_read();
        t_mid_session();
        t_badlen();
        t_stop();
        t_addr0();
        t_no_sink();
        t_overrun();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule